// File: doc/BRIEF.md
# Sampled-Clock Toggle Flip-Flop

This block is a toggle storage bit that runs entirely on a fast system clock. A second, slower "toggle clock" comes in as ordinary data and is sampled on every system edge. The block never uses it as a real clock. A toggle request input `t_i` decides whether a qualifying toggle-clock condition flips the stored bit.

The block has two modes of operation. In level mode, the bit inverts on every system cycle in which the toggle clock and the request are both high. In falling-edge mode, a detector first turns each sampled 1-to-0 transition of the toggle clock into a pulse one system cycle long. That pulse replaces the level as the enable, and it is combined with the request exactly as in level mode.

The mode can be fixed by a parameter or taken from an input at run time. The stored bit can be shown through an optional delay line, so that its timing can be lined up with other paths. The detector pulse is also brought out for observation.

Top module: `tgl_ff_sampled`

## Requirements
- R1: In level mode, when `tclk_i` and `t_i` are both 1 at a system clock edge, the stored bit inverts at that edge.
- R2: In level mode, for the input pairs (`tclk_i`,`t_i`) of (0,0), (0,1) and (1,0), the stored bit keeps its value.
- R3: In edge mode, the stored bit inverts at an edge where `fall_o` is 1 and `t_i` is 1. In every other case it keeps its value.
- R4: `fall_o` is 1 only when the toggle clock sampled at the previous system edge was 1 and the current `tclk_i` is 0. Steady levels and rising transitions give 0.
- R5: `fall_o` is never high on two consecutive system cycles.
- R6: A synchronous reset (`rst_i` = 1 at an edge) clears the stored bit, the delay line and the toggle-clock history to 0.
- R7: If `tclk_i` is held at 1 while reset is released, no edge-mode toggle and no `fall_o` pulse occur until `tclk_i` actually falls.
- R8: With `MODE` = 2 (run-time selection), `mode_i` = 0 selects level mode and `mode_i` = 1 selects edge mode. `MODE` = 0 forces level mode and `MODE` = 1 forces edge mode.
- R9: `q_o` equals the stored bit as it was `EXTRA_DLY` system edges earlier. With `EXTRA_DLY` = 0, `q_o` is the stored bit itself, updated one edge after the inputs are sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| tclk_i | input | 1 | Toggle clock, sampled as data |
| t_i | input | 1 | Toggle request |
| mode_i | input | 1 | Run-time mode (0 level, 1 falling edge); used only when MODE = 2 |
| q_o | output | 1 | Stored bit after the optional delay line |
| fall_o | output | 1 | Falling-edge detector pulse |

## Verification
The in-RTL assertions check on every cycle that an enabled request inverts the stored bit and that any other input leaves it stable. They also check that the detector pulse is only produced on a sampled 1-to-0 transition, that it never lasts two cycles, and that reset clears the state.

Other behaviours can only be shown by the bench's scenarios, checked against a behavioural reference model. These are the output latency through the delay line, the silence after a reset released with the toggle clock high, and the effect of switching the mode input while the toggle clock is high. The same applies to mixed random streams in both modes.

// File: rtl/tgl_pkg.sv
package tgl_pkg;
   typedef enum int {
      TGL_LEVEL   = 0,
      TGL_EDGE    = 1,
      TGL_RUNTIME = 2
   } tgl_mode_e;

   localparam int TGL_MODE_MAX = 2;
endpackage

// File: rtl/tgl_fall_det.sv
module tgl_fall_det (
   input  logic clk_i,
   input  logic rst_i,
   input  logic lvl_i,
   output logic fall_o
);
   logic lvl_d;

   always_ff @(posedge clk_i) begin
      if (rst_i) lvl_d <= 1'b0;
      else       lvl_d <= lvl_i;
   end

   assign fall_o = lvl_d & ~lvl_i;

   AST_FALL_ONLY: assert property (@(posedge clk_i) disable iff (rst_i)
      fall_o |-> (!lvl_i && $past(lvl_i) && !$past(rst_i))); // R4

   AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
      fall_o |=> !fall_o); // R5

   AST_HIST_CLEAR: assert property (@(posedge clk_i)
      rst_i |=> !fall_o); // R7
endmodule

// File: rtl/tgl_core.sv
module tgl_core (
   input  logic clk_i,
   input  logic rst_i,
   input  logic en_i,
   input  logic t_i,
   output logic st_o
);
   logic st_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) st_q <= 1'b0;
      else       st_q <= st_q ^ (en_i & t_i);
   end

   assign st_o = st_q;

   AST_TOGGLE: assert property (@(posedge clk_i) disable iff (rst_i)
      (en_i && t_i) |=> (st_o != $past(st_o))); // R1

   AST_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
      !(en_i && t_i) |=> $stable(st_o)); // R2

   AST_RST_CLEAR: assert property (@(posedge clk_i)
      rst_i |=> !st_o); // R6
endmodule

// File: rtl/tgl_dly.sv
module tgl_dly #(
   parameter int DEPTH = 0
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic d_i,
   output logic d_o
);
   generate
      if (DEPTH < 0) begin : g_bad
         $error("tgl_dly: DEPTH must be non-negative");
      end
      if (DEPTH <= 0) begin : g_pass
         assign d_o = d_i;
      end else begin : g_line
         logic [DEPTH-1:0] stg;
         for (genvar i = 0; i < DEPTH; i++) begin : g_stg
            always_ff @(posedge clk_i) begin
               if (rst_i)       stg[i] <= 1'b0;
               else if (i == 0) stg[i] <= d_i;
               else             stg[i] <= stg[(i > 0) ? i-1 : 0];
            end
         end
         assign d_o = stg[DEPTH-1];

         AST_DLY_CLEAR: assert property (@(posedge clk_i)
            rst_i |=> !d_o); // R6
      end
   endgenerate
endmodule

// File: rtl/tgl_ff_sampled.sv
module tgl_ff_sampled #(
   parameter int MODE      = tgl_pkg::TGL_RUNTIME,
   parameter int EXTRA_DLY = 0
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic tclk_i,
   input  logic t_i,
   input  logic mode_i,
   output logic q_o,
   output logic fall_o
);
   logic edge_sel;
   logic fall_pls;
   logic core_en;
   logic core_st;

   generate
      if (MODE < 0 || MODE > tgl_pkg::TGL_MODE_MAX) begin : g_bad_mode
         $error("tgl_ff_sampled: MODE out of range");
      end
      if (MODE == tgl_pkg::TGL_RUNTIME) begin : g_rt
         assign edge_sel = mode_i;
      end else begin : g_fix
         logic unused_mode;
         assign unused_mode = mode_i;
         assign edge_sel = (MODE == tgl_pkg::TGL_EDGE);
      end
   endgenerate

   tgl_fall_det i_det (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .lvl_i  (tclk_i),
      .fall_o (fall_pls)
   );

   assign core_en = edge_sel ? fall_pls : tclk_i;

   tgl_core i_core (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .en_i  (core_en),
      .t_i   (t_i),
      .st_o  (core_st)
   );

   tgl_dly #(.DEPTH(EXTRA_DLY)) i_dly (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .d_i   (core_st),
      .d_o   (q_o)
   );

   assign fall_o = fall_pls;

   AST_EDGE_GATE: assert property (@(posedge clk_i) disable iff (rst_i)
      (edge_sel && !(fall_pls && t_i)) |=> $stable(core_st)); // R3

   AST_LEVEL_SEL: assert property (@(posedge clk_i) disable iff (rst_i)
      (!edge_sel && tclk_i && t_i) |=> (core_st != $past(core_st))); // R8
endmodule

// File: tb/test_tgl_ff_sampled.sv
module test_tgl_ff_sampled;
   localparam int CLK_P = 10;
   localparam int DLY   = 2;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic tclk = 1'b0;
   logic t = 1'b0;
   logic mode = 1'b0;
   logic q_o;
   logic fall_o;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   int m_prev = 0;
   int m_hist[DLY+1];

   always #(CLK_P/2) clk = ~clk;

   tgl_ff_sampled #(.MODE(2), .EXTRA_DLY(DLY)) i_tgl_ff_sampled (
      .clk_i  (clk),
      .rst_i  (rst),
      .tclk_i (tclk),
      .t_i    (t),
      .mode_i (mode),
      .q_o    (q_o),
      .fall_o (fall_o)
   );

   task automatic check(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic step(input logic r, input logic m, input logic c, input logic tt, input string tag);
      int pls;
      int en;
      rst = r; mode = m; tclk = c; t = tt;
      #1;
      pls = (m_prev == 1 && c == 1'b0) ? 1 : 0;
      check(tag, "fall_o", int'(fall_o), pls);
      @(posedge clk);
      if (r) begin
         m_prev = 0;
         for (int i = 0; i <= DLY; i++) m_hist[i] = 0;
      end else begin
         en = m ? pls : int'(c);
         for (int i = DLY; i > 0; i--) m_hist[i] = m_hist[i-1];
         m_hist[0] = m_hist[0] ^ (en & int'(tt));
         m_prev = int'(c);
      end
      @(negedge clk);
      check(tag, "q_o", int'(q_o), m_hist[DLY]);
   endtask

   initial begin
      #(CLK_P * 100000);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      logic [7:0] lfsr;
      for (int i = 0; i <= DLY; i++) m_hist[i] = 0;
      @(negedge clk);
      // R6: reset state, toggle clock moving during reset
      step(1, 0, 1, 1, "R6");
      step(1, 0, 0, 1, "R6");
      step(1, 1, 1, 1, "R6");
      step(1, 1, 0, 0, "R6");
      // R1 / R2: level mode, all input pairs
      for (int i = 0; i < 16; i++)
         step(0, 0, i[0], i[1], (i[0] & i[1]) ? "R1" : "R2");
      step(0, 0, 1, 1, "R1");
      step(0, 0, 1, 1, "R1");
      step(0, 0, 1, 1, "R1");
      // R9: quiet cycles expose the delayed output
      for (int i = 0; i < 4; i++) step(0, 0, 0, 0, "R9");
      // R3 / R4 / R5: edge mode
      step(0, 1, 1, 1, "R4");
      step(0, 1, 1, 1, "R4");
      step(0, 1, 0, 1, "R3");
      step(0, 1, 0, 1, "R5");
      step(0, 1, 0, 1, "R5");
      step(0, 1, 1, 1, "R4");
      step(0, 1, 0, 0, "R3");
      step(0, 1, 1, 0, "R4");
      step(0, 1, 0, 1, "R3");
      for (int i = 0; i < 3; i++) step(0, 1, 0, 0, "R9");
      // R6: reset after activity clears the bit and the delay line
      step(1, 1, 1, 0, "R6");
      step(1, 1, 0, 0, "R6");
      step(0, 1, 0, 0, "R6");
      // R7: toggle clock high across reset release
      step(1, 1, 1, 1, "R7");
      step(1, 1, 1, 1, "R7");
      for (int i = 0; i < 4; i++) step(0, 1, 1, 1, "R7");
      step(0, 1, 0, 1, "R3");
      for (int i = 0; i < 3; i++) step(0, 1, 0, 0, "R9");
      // R8: run-time mode switching with toggle clock high
      step(0, 0, 1, 1, "R8");
      step(0, 0, 1, 1, "R8");
      step(0, 1, 1, 1, "R8");
      step(0, 1, 1, 1, "R8");
      step(0, 0, 1, 1, "R8");
      step(0, 1, 0, 1, "R8");
      for (int i = 0; i < 3; i++) step(0, 0, 0, 0, "R9");
      // mixed random stream in both modes
      lfsr = 8'hA5;
      for (int i = 0; i < 300; i++) begin
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         if (lfsr[2])
            step(0, lfsr[2], lfsr[0], lfsr[1], "R3");
         else
            step(0, lfsr[2], lfsr[0], lfsr[1], (lfsr[0] & lfsr[1]) ? "R1" : "R2");
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule